// File: doc/BRIEF.md
# Region Permission Checker

This block decides what access a request at a given byte address is allowed under a set of protection regions. It is purely combinational. For each region it takes an 8-bit configuration byte and a 30-bit word-address register. It also takes the 32-bit request address and the current privilege level. It returns whether a region matched, which region it was, and a 3-bit permission vector ordered execute, write, read.

Each region is disabled, an exact 4-byte word, or a naturally aligned power-of-two span. A power-of-two span is encoded by the run of trailing ones in its address register. When several regions cover the address, the lowest-numbered one decides. Machine mode keeps full access unless the deciding region is locked. When nothing matches, machine mode gets full access and lower privileges get none. The caller uses the permission vector to accept or fault a fetch, load or store. Fault handling lives outside this block.

Top module: `pmpchk_top`

## Requirements
- R1: A region whose mode field (configuration bits [4:3]) is 0 never matches, whatever its address register holds.
- R2: In mode 2 a region matches only when request address bits [31:2] equal its 30-bit address register. Request bits [1:0] are ignored.
- R3: In mode 3, when the address register has t trailing ones (t < 30), the region covers the aligned 2^(t+3)-byte span. The span's word base is the register with those t ones cleared.
- R4: In mode 3 an address register of all ones (0x3FFFFFFF) matches every request address.
- R5: When several regions match, hitIndex reports the lowest-numbered one, and only that region's bits decide the permission.
- R6: With privilege 2'b11 (machine) and an unlocked matching region (configuration bit 7 clear), permXwr is 3'b111 regardless of the region's permission bits.
- R7: With a locked matching region, or any privilege other than 2'b11, permXwr equals the region's configuration bits {bit2 execute, bit1 write, bit0 read}.
- R8: With no match, permXwr is 3'b111 at privilege 2'b11 and 3'b000 at any other privilege.
- R9: Parameter RANGE_AS_WORD selects how mode 1 behaves. At 0 (default) a mode-1 region never matches. At 1 it matches like mode 2.
- R10: hitValid is 1 exactly when some region matches. When it is 0, hitIndex is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reqAddr | input | 32 | Byte address of the request |
| privLevel | input | 2 | Current privilege level, 2'b11 is machine |
| cfgFlat | input | NREG*8 | Configuration byte of region i at bits [8i+7:8i] |
| addrFlat | input | NREG*30 | Word-address register of region i at bits [30i+29:30i] |
| hitValid | output | 1 | Some region matched |
| hitIndex | output | 4 | Lowest-numbered matching region |
| permXwr | output | 3 | Granted permission {execute, write, read} |

## Verification
The bench targets several corner cases, each with a characteristic failure:
- Power-of-two span edges: the last byte inside and the first byte past a 32-byte span. A mask off by one bit either grows the span or shrinks it.
- All-ones address register: a design that special-cases it wrongly misses the top or bottom of memory.
- Overlapping regions: the bench sets disagreeing permissions, so a priority encoder that favours the highest index shows up as the wrong permission.
- Lock and privilege: unlocked versus locked regions are tested in machine mode, and matched versus unmatched requests in user mode. This exposes a design that grants machine mode full access even through a locked region, or that grants anything to user mode on a miss.
- Disabled and mode-1 regions: a design that forgets to skip them reports a false hit.

// File: rtl/pmpchk_pkg.sv
package pmpchk_pkg;
  localparam int MAX_REGIONS = 16;
  localparam int SEL_W       = $clog2(MAX_REGIONS);
  localparam int CFG_W       = 8;
  localparam int ADR_W       = 30;
  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_RANGE = 2'd1,
    MODE_WORD  = 2'd2,
    MODE_POW2  = 2'd3
  } regionMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             hit;
    logic             grantAll;
    logic [SEL_W-1:0] idx;
  } selStrobe_t;
endpackage

// File: rtl/pmpchk_match_dp.sv
module pmpchk_match_dp
  import pmpchk_pkg::*;
#(
  parameter int NREG          = 16,
  parameter bit RANGE_AS_WORD = 1'b0
) (
  input  logic [31:0]           reqAddr,
  input  logic [NREG*CFG_W-1:0] cfgFlat,
  input  logic [NREG*ADR_W-1:0] addrFlat,
  input  selStrobe_t            sel,
  output logic [NREG-1:0]       hitVec,
  output logic [NREG-1:0]       lockVec,
  output logic [2:0]            permXwr
);
  logic [ADR_W-1:0] reqWord;
  logic [2:0]       xwrArr [MAX_REGIONS];

  assign reqWord = reqAddr[31:2];

  for (genvar g = 0; g < MAX_REGIONS; g++) begin : g_region
    if (g < NREG) begin : g_live
      logic [CFG_W-1:0] cfg;
      logic [ADR_W-1:0] adr;
      logic [ADR_W-1:0] spanMask;
      logic             exactHit;
      logic             spanHit;
      regionMode_e      mode;

      assign cfg  = cfgFlat[g*CFG_W +: CFG_W];
      assign adr  = addrFlat[g*ADR_W +: ADR_W];
      assign mode = regionMode_e'(cfg[4:3]);
      // adr ^ (adr+1) covers the trailing ones plus the first zero;
      // an all-ones register wraps to give an empty mask.
      assign spanMask = ~(adr ^ (adr + ADR_W'(1)));
      assign exactHit = (reqWord == adr);
      assign spanHit  = ((reqWord ^ adr) & spanMask) == '0;

      always_comb begin
        unique case (mode)
          MODE_OFF:   hitVec[g] = 1'b0;
          MODE_RANGE: hitVec[g] = RANGE_AS_WORD ? exactHit : 1'b0;
          MODE_WORD:  hitVec[g] = exactHit;
          MODE_POW2:  hitVec[g] = spanHit;
          default:    hitVec[g] = 1'b0;
        endcase
      end
      assign lockVec[g] = cfg[7];
      assign xwrArr[g]  = cfg[2:0];
    end else begin : g_pad
      assign xwrArr[g] = 3'b000;
    end
  end

  always_comb begin
    if (sel.grantAll)   permXwr = 3'b111;
    else if (sel.hit)   permXwr = xwrArr[sel.idx];
    else                permXwr = 3'b000;
  end
endmodule

// File: rtl/pmpchk_prio_ctrl.sv
module pmpchk_prio_ctrl
  import pmpchk_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic [NREG-1:0] hitVec,
  input  logic [NREG-1:0] lockVec,
  input  logic [1:0]      privLevel,
  output selStrobe_t      sel
);
  logic isMachine;
  logic selLocked;

  assign isMachine = (privLevel == PRIV_MACHINE);

  always_comb begin
    sel       = '0;
    selLocked = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        sel.hit   = 1'b1;
        sel.idx   = SEL_W'(i);
        selLocked = lockVec[i];
      end
    end
    sel.grantAll = isMachine && (!sel.hit || !selLocked);
  end
endmodule

// File: rtl/pmpchk_top.sv
module pmpchk_top
  import pmpchk_pkg::*;
#(
  parameter int NREG          = 16,
  parameter bit RANGE_AS_WORD = 1'b0
) (
  input  logic [31:0]           reqAddr,
  input  logic [1:0]            privLevel,
  input  logic [NREG*CFG_W-1:0] cfgFlat,
  input  logic [NREG*ADR_W-1:0] addrFlat,
  output logic                  hitValid,
  output logic [SEL_W-1:0]      hitIndex,
  output logic [2:0]            permXwr
);
  logic [NREG-1:0] hitVec;
  logic [NREG-1:0] lockVec;
  selStrobe_t      sel;

  pmpchk_match_dp #(.NREG(NREG), .RANGE_AS_WORD(RANGE_AS_WORD)) dp (
    .reqAddr (reqAddr),
    .cfgFlat (cfgFlat),
    .addrFlat(addrFlat),
    .sel     (sel),
    .hitVec  (hitVec),
    .lockVec (lockVec),
    .permXwr (permXwr)
  );

  pmpchk_prio_ctrl #(.NREG(NREG)) ctrl (
    .hitVec   (hitVec),
    .lockVec  (lockVec),
    .privLevel(privLevel),
    .sel      (sel)
  );

  assign hitValid = sel.hit;
  assign hitIndex = sel.idx;
endmodule

// File: rtl/pmpchk_top_chk.sv
module pmpchk_top_chk
  import pmpchk_pkg::*;
#(
  parameter int NREG = 16
) (
  input logic [31:0]           reqAddr,
  input logic [1:0]            privLevel,
  input logic [NREG*CFG_W-1:0] cfgFlat,
  input logic [NREG*ADR_W-1:0] addrFlat,
  input logic                  hitValid,
  input logic [SEL_W-1:0]      hitIndex,
  input logic [2:0]            permXwr
);
  logic [CFG_W-1:0] hitCfg;
  assign hitCfg = cfgFlat[{hitIndex, 3'b000} +: CFG_W];

  always_comb begin
    if (!hitValid) begin
      assert_nohit_index_R10: assert (hitIndex == '0);
      assert_nohit_perm_R8: assert (permXwr == ((privLevel == PRIV_MACHINE) ? 3'b111 : 3'b000));
    end else begin
      assert_hit_enabled_R1: assert (hitCfg[4:3] != 2'b00);
      if (privLevel == PRIV_MACHINE && !hitCfg[7]) begin
        assert_machine_full_R6: assert (permXwr == 3'b111);
      end else begin
        assert_region_bits_R7: assert (permXwr == hitCfg[2:0]);
      end
    end
  end
endmodule

bind pmpchk_top pmpchk_top_chk #(.NREG(NREG)) chk (
  .reqAddr  (reqAddr),
  .privLevel(privLevel),
  .cfgFlat  (cfgFlat),
  .addrFlat (addrFlat),
  .hitValid (hitValid),
  .hitIndex (hitIndex),
  .permXwr  (permXwr)
);

// File: tb/pmpchk_top_test.sv
module pmpchk_top_test;
  localparam int NREG = 16;
  localparam bit RAW  = 1'b0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [31:0]      reqAddr;
  logic [1:0]       privLevel;
  logic [7:0]       cfgArr [NREG];
  logic [29:0]      adrArr [NREG];
  logic [NREG*8-1:0]  cfgFlat;
  logic [NREG*30-1:0] addrFlat;
  logic             hitValid;
  logic [3:0]       hitIndex;
  logic [2:0]       permXwr;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      cfgFlat[i*8 +: 8]   = cfgArr[i];
      addrFlat[i*30 +: 30] = adrArr[i];
    end
  end

  pmpchk_top #(.NREG(NREG), .RANGE_AS_WORD(RAW)) uut (
    .reqAddr(reqAddr), .privLevel(privLevel), .cfgFlat(cfgFlat), .addrFlat(addrFlat),
    .hitValid(hitValid), .hitIndex(hitIndex), .permXwr(permXwr)
  );

  // Reference model: {valid, index, perm}
  function automatic logic [7:0] model(input logic [31:0] a, input logic [1:0] p);
    logic [29:0] w, m;
    logic hit;
    int t;
    w = a[31:2];
    for (int i = 0; i < NREG; i++) begin
      hit = 1'b0;
      case (cfgArr[i][4:3])
        2'd1: hit = RAW && (w == adrArr[i]);
        2'd2: hit = (w == adrArr[i]);
        2'd3: begin
          t = 0;
          while (t < 30 && adrArr[i][t]) t++;
          m = '0;
          for (int b = 0; b < 30; b++) m[b] = (b > t);
          hit = ((w & m) == (adrArr[i] & m));
        end
        default: hit = 1'b0;
      endcase
      if (hit) begin
        if (p == 2'b11 && !cfgArr[i][7]) return {1'b1, 4'(i), 3'b111};
        return {1'b1, 4'(i), cfgArr[i][2:0]};
      end
    end
    return {1'b0, 4'd0, (p == 2'b11) ? 3'b111 : 3'b000};
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    logic [7:0] act;
    #1;
    act = {hitValid, hitIndex, permXwr};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s addr=%h priv=%0d actual=%h expected=%h", req, reqAddr, privLevel, act, exp);
    end
  endtask

  task automatic clearAll();
    for (int i = 0; i < NREG; i++) begin cfgArr[i] = 8'h00; adrArr[i] = 30'h0; end
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic [1:0] p, input logic [7:0] exp);
    reqAddr = a; privLevel = p;
    check(req, exp);
  endtask

  initial begin
    clearAll();
    reqAddr = 32'h0; privLevel = 2'b11;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state: nothing configured (R8, R10)
    probe("R8", 32'h0000_1234, 2'b11, {1'b0, 4'd0, 3'b111});
    probe("R8", 32'h0000_1234, 2'b00, {1'b0, 4'd0, 3'b000});
    // R1: disabled region 0 ignored, region 1 word match
    adrArr[0] = 30'h400; cfgArr[0] = 8'h07;
    adrArr[1] = 30'h400; cfgArr[1] = 8'h10 | 8'h01;
    probe("R1", 32'h0000_1000, 2'b00, {1'b1, 4'd1, 3'b001});
    // R2: word match ignores low bits, next word misses
    probe("R2", 32'h0000_1003, 2'b00, {1'b1, 4'd1, 3'b001});
    probe("R2", 32'h0000_1004, 2'b00, {1'b0, 4'd0, 3'b000});
    clearAll();
    // R3: 32-byte span at 0x1000
    adrArr[2] = 30'h403; cfgArr[2] = 8'h18 | 8'h03;
    probe("R3", 32'h0000_1000, 2'b00, {1'b1, 4'd2, 3'b011});
    probe("R3", 32'h0000_101F, 2'b00, {1'b1, 4'd2, 3'b011});
    probe("R3", 32'h0000_1020, 2'b00, {1'b0, 4'd0, 3'b000});
    probe("R3", 32'h0000_0FFF, 2'b00, {1'b0, 4'd0, 3'b000});
    // R4: all-ones covers everything
    adrArr[5] = 30'h3FFF_FFFF; cfgArr[5] = 8'h18 | 8'h04;
    probe("R4", 32'hFFFF_FFFC, 2'b01, {1'b1, 4'd5, 3'b100});
    probe("R4", 32'h0000_0000, 2'b01, {1'b1, 4'd5, 3'b100});
    // R5: region 2 wins over 5 inside its span
    probe("R5", 32'h0000_1010, 2'b00, {1'b1, 4'd2, 3'b011});
    // R6: machine through unlocked region 2
    probe("R6", 32'h0000_1010, 2'b11, {1'b1, 4'd2, 3'b111});
    // R7: lock region 2, machine sees its bits
    cfgArr[2] = 8'h80 | 8'h18 | 8'h03;
    probe("R7", 32'h0000_1010, 2'b11, {1'b1, 4'd2, 3'b011});
    clearAll();
    // R9: mode 1 with RANGE_AS_WORD=0 never matches
    adrArr[3] = 30'h400; cfgArr[3] = 8'h08 | 8'h07;
    probe("R9", 32'h0000_1000, 2'b00, {1'b0, 4'd0, 3'b000});
    probe("R10", 32'h0000_1000, 2'b11, {1'b0, 4'd0, 3'b111});
    // random mix against model (fixed seed)
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < NREG; i++) begin
        cfgArr[i] = 8'($urandom) & 8'h9F;
        adrArr[i] = 30'($urandom);
        if ($urandom_range(0, 3) == 0) adrArr[i] = adrArr[i] | 30'h00F;
      end
      if ($urandom_range(0, 1) == 1) begin
        int k;
        k = $urandom_range(0, NREG - 1);
        reqAddr = {adrArr[k], 2'($urandom)} ^ 32'($urandom_range(0, 63));
      end else begin
        reqAddr = $urandom;
      end
      privLevel = 2'($urandom);
      check("R5", model(reqAddr, privLevel));
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule